// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block runs one card command at a time on a single bidirectional command wire. Software fills in a 6-bit command index, a 32-bit argument and a command-setup word through a small word-addressed register port. It then sets a start bit. The engine serializes a 48-bit command frame that carries its own CRC7. It then lets go of the wire and waits a programmable number of card-clock cycles for a reply start bit. The reply is either 48 or 136 bits long, and the engine checks its CRC.

A captured reply is drained through a response port that returns 16 bits per read, most significant part first. Completion and timeout are reported as sticky flags that are cleared by writing one to them. A single interrupt line is raised for any flag whose mask bit is clear. The card clock itself is generated outside the block. It arrives here as `cclk_en`, a one-cycle enable marking each card-clock rising edge. All line activity and all sampling of `cmd_i` happen only on cycles where `cclk_en` is high.

Register map (word addresses):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 2 starts a command |
| 1 | status | bit 0 busy, bit 5 reply CRC error |
| 2 | index | 6-bit command index |
| 3 | argument | 32-bit argument |
| 4 | setup | bits 2:0 format, bit 7 init, bit 6 busy, bit 3 data enable, bit 4 write, bits 10:9 bus width |
| 5 | reply timeout | 16-bit count |
| 6 | mask | bits 2 and 9 |
| 7 | flags | bit 2 done, bit 9 timeout |
| 8 | response | successive 16-bit reads |

Top module: `sdcmd_engine`

## Requirements
- R1: Writing 1 to bit 2 of the control register starts a command. The frame is sent MSB first on `cmd_o`, with `cmd_oe` high, one bit per card-clock tick. The frame is a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a CRC7 over those 40 bits (polynomial x^7+x^3+1, zero seed), and a 1 end bit. `cmd_oe` is low whenever no frame or wake-up burst is being driven.
- R2: When bit 7 (init) of the setup word is set, exactly 80 card-clock ticks of high line are driven with `cmd_oe` high before the start bit. Otherwise the start bit is the first driven bit.
- R3: A start written while a command is still in progress is ignored, and no second frame follows.
- R4: The response format in setup bits 2:0 controls what happens after the frame. With code 0, the done flag (flags bit 2) is set once the end bit has been sent, and no reply is awaited.
- R5: After the frame, the line is released for two ticks. From the next tick on, a low sample on `cmd_i` is accepted as a reply start bit. If the first T samples in that window are all high, where T is the timeout register value, the timeout flag (flags bit 9) is set and the done flag is not.
- R6: Format code 2 captures a 136-bit reply, read back as nine 16-bit words from the most significant end. The ninth word holds reply bits 7:0 in its upper byte and zero in its lower byte. Every other nonzero code captures a 48-bit reply, read back as bits 47:32, then 31:16, then 15:0. The done flag is set in both cases.
- R7: The reply CRC7 is checked over bits 47:8 of a 48-bit reply, or bits 127:8 of a 136-bit reply, against the received bits 7:1. On a mismatch, status bit 5 is set and the done flag is still set. Format code 3 is never flagged. The bit clears when the next command starts.
- R8: Writing 1 to bit 2 or bit 9 of the flags register clears that flag only. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some flag is set whose mask bit (same position) is 0. After reset both mask bits are 1.
- R10: After reset, `cmd_oe` and `irq` are low, and the status and flags registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_en | input | 1 | Card-clock rising-edge enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (a response read pops a word) |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| cmd_i | input | 1 | Command line as seen at the pad |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| irq | output | 1 | Unmasked flag interrupt |

## Verification
The hardest cases to reach from the ports sit on the reply-timeout boundary. A start bit that lands on the last allowed sample must be accepted, and one a single tick later must time out. The bench reaches both by sampling the moment `cmd_oe` falls and counting ticks from there. It places the emulated card's start bit at the last legal sample and one tick beyond, with a short timeout value. A corrupted reply, a format-3 reply carrying a bad CRC, and a second start written in the middle of a frame are each driven deliberately from the card model and the register port.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_SEND, ST_TURN, ST_WAIT, ST_RECV
  } seq_st_t;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_STAT  = 4'd1;
  localparam logic [3:0] REG_IDX   = 4'd2;
  localparam logic [3:0] REG_ARG   = 4'd3;
  localparam logic [3:0] REG_SETUP = 4'd4;
  localparam logic [3:0] REG_RTO   = 4'd5;
  localparam logic [3:0] REG_MASK  = 4'd6;
  localparam logic [3:0] REG_FLAGS = 4'd7;
  localparam logic [3:0] REG_RESP  = 4'd8;

  localparam int FLAG_DONE_BIT = 2;
  localparam int FLAG_TOUT_BIT = 9;
  localparam int START_BIT     = 2;

  // one serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RTO_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              start_p,
  output logic [5:0]        idx,
  output logic [31:0]       arg,
  output logic [10:0]       setup,
  output logic [RTO_W-1:0]  rto,
  output logic              irq,
  output logic              resp_pop,
  input  logic [WORD_W-1:0] resp_word,
  input  logic              busy,
  input  logic              crc_err,
  input  logic              done_p,
  input  logic              tout_p
);

  // index 0 = done (bit 2), index 1 = timeout (bit 9)
  logic [1:0] flag_q, mask_q, clr;

  always_comb begin
    clr = 2'b00;
    if (wr_en && wr_addr == ADDR_W'(REG_FLAGS))
      clr = {wr_data[FLAG_TOUT_BIT], wr_data[FLAG_DONE_BIT]};
  end

  assign resp_pop = rd_en && rd_addr == ADDR_W'(REG_RESP);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_p <= 1'b0;
      idx     <= '0;
      arg     <= '0;
      setup   <= '0;
      rto     <= '1;
      mask_q  <= 2'b11;
      flag_q  <= 2'b00;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      start_p <= wr_en && wr_addr == ADDR_W'(REG_CTRL) && wr_data[START_BIT];
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(REG_IDX):   idx   <= wr_data[5:0];
          ADDR_W'(REG_ARG):   arg   <= wr_data;
          ADDR_W'(REG_SETUP): setup <= wr_data[10:0];
          ADDR_W'(REG_RTO):   rto   <= wr_data[RTO_W-1:0];
          ADDR_W'(REG_MASK):  mask_q <= {wr_data[FLAG_TOUT_BIT], wr_data[FLAG_DONE_BIT]};
          default: ;
        endcase
      end
      flag_q <= (flag_q & ~clr) | {tout_p, done_p};
      irq    <= |(flag_q & ~mask_q);
      if (rd_en) begin
        rd_data <= '0;
        case (rd_addr)
          ADDR_W'(REG_STAT):  rd_data <= {26'd0, crc_err, 4'd0, busy};
          ADDR_W'(REG_IDX):   rd_data <= {26'd0, idx};
          ADDR_W'(REG_ARG):   rd_data <= arg;
          ADDR_W'(REG_SETUP): rd_data <= {21'd0, setup};
          ADDR_W'(REG_RTO):   rd_data <= 32'(rto);
          ADDR_W'(REG_MASK):  rd_data <= {22'd0, mask_q[1], 6'd0, mask_q[0], 2'd0};
          ADDR_W'(REG_FLAGS): rd_data <= {22'd0, flag_q[1], 6'd0, flag_q[0], 2'd0};
          ADDR_W'(REG_RESP):  rd_data <= 32'(resp_word);
          default: ;
        endcase
      end
    end
  end

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(REG_FLAGS) && wr_data[FLAG_DONE_BIT] && !done_p) |=> !flag_q[0]);

  assert_irq_needs_unmasked_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flag_q & ~mask_q)));

endmodule

// File: rtl/sdcmd_resp.sv
module sdcmd_resp #(
  parameter int WORD_W = 16,
  parameter int LONG   = 136,
  parameter int SHORT  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              is_long,
  input  logic [LONG-1:0]   raw,
  input  logic              pop,
  output logic [WORD_W-1:0] word
);

  localparam int NWORDS = (LONG + WORD_W - 1) / WORD_W;
  localparam int BUF_W  = NWORDS * WORD_W;

  logic [BUF_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst)
      buf_q <= '0;
    else if (load)
      buf_q <= is_long ? (BUF_W'(raw) << (BUF_W - LONG))
                       : (BUF_W'(raw[SHORT-1:0]) << (BUF_W - SHORT));
    else if (pop)
      buf_q <= buf_q << WORD_W;
  end

  assign word = buf_q[BUF_W-1 -: WORD_W];

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int INIT_CYC = 80,
  parameter int RTO_W    = 16,
  parameter int LONG     = 136,
  parameter int SHORT    = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [5:0]       idx,
  input  logic [31:0]      arg,
  input  logic [2:0]       fmt_in,
  input  logic             init_in,
  input  logic [RTO_W-1:0] rto,
  input  logic             cmd_i,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic             busy,
  output logic             crc_err,
  output logic             done_p,
  output logic             tout_p,
  output logic             resp_load,
  output logic             resp_long,
  output logic [LONG-1:0]  resp_raw
);

  localparam int CNT_W = $clog2(LONG + INIT_CYC);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [47:0]      txsh;
  logic [LONG-1:0]  rxsh, rx_nx;
  logic [6:0]       crc;
  logic [RTO_W-1:0] tcnt;
  logic [2:0]       fmt;
  logic [CNT_W-1:0] rx_last, crc_lo, crc_end;

  assign rx_nx   = {rxsh[LONG-2:0], cmd_i};
  assign rx_last = (fmt == 3'd2) ? CNT_W'(LONG - 1) : CNT_W'(SHORT - 1);
  assign crc_lo  = (fmt == 3'd2) ? CNT_W'(8) : CNT_W'(0);
  assign crc_end = rx_last - CNT_W'(7);

  assign cmd_o     = (st == ST_SEND) ? txsh[47] : 1'b1;
  assign cmd_oe    = (st == ST_SEND) || (st == ST_WAKE);
  assign busy      = (st != ST_IDLE);
  assign resp_long = (fmt == 3'd2);
  assign resp_raw  = rxsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; txsh <= '1; rxsh <= '0; crc <= '0;
      tcnt <= '0; fmt <= '0; crc_err <= 1'b0;
      done_p <= 1'b0; tout_p <= 1'b0; resp_load <= 1'b0;
    end else begin
      done_p <= 1'b0; tout_p <= 1'b0; resp_load <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          fmt     <= fmt_in;
          txsh    <= {2'b01, idx, arg, crc7_of40({2'b01, idx, arg}), 1'b1};
          cnt     <= '0;
          crc_err <= 1'b0;
          st      <= init_in ? ST_WAKE : ST_SEND;
        end
        ST_WAKE: if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(INIT_CYC - 1)) begin cnt <= '0; st <= ST_SEND; end
        end
        ST_SEND: if (tick) begin
          txsh <= {txsh[46:0], 1'b1};
          cnt  <= cnt + 1'b1;
          if (cnt == CNT_W'(47)) begin
            cnt <= '0;
            if (fmt == 3'd0) begin done_p <= 1'b1; st <= ST_IDLE; end
            else st <= ST_TURN;
          end
        end
        ST_TURN: if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(1)) begin tcnt <= '0; st <= ST_WAIT; end
        end
        ST_WAIT: if (tick) begin
          if (!cmd_i) begin
            rxsh <= rx_nx; crc <= '0; cnt <= CNT_W'(1); st <= ST_RECV;
          end else if (tcnt == rto - RTO_W'(1)) begin
            tout_p <= 1'b1; st <= ST_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        ST_RECV: if (tick) begin
          rxsh <= rx_nx;
          cnt  <= cnt + 1'b1;
          if (cnt >= crc_lo && cnt < crc_end) crc <= crc7_step(crc, cmd_i);
          if (cnt == rx_last) begin
            done_p    <= 1'b1;
            resp_load <= 1'b1;
            crc_err   <= (fmt != 3'd3) && (rx_nx[7:1] != crc);
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_start_ignored_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && start && !tick) |=> $stable(st));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    !(done_p && tout_p));

  assert_tout_only_waiting_R5: assert property (@(posedge clk) disable iff (rst)
    tout_p |-> $past(st) == ST_WAIT);

  assert_release_after_frame_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $past(st) == ST_SEND);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RTO_W    = 16,
  parameter int WORD_W   = 16,
  parameter int INIT_CYC = 80,
  parameter int LONG     = 136,
  parameter int SHORT    = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cclk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              cmd_i,
  output logic              cmd_o,
  output logic              cmd_oe,
  output logic              irq
);

  logic              start_p, resp_pop, busy, crc_err, done_p, tout_p;
  logic              resp_load, resp_long;
  logic [5:0]        idx;
  logic [31:0]       arg;
  logic [10:0]       setup;
  logic [RTO_W-1:0]  rto;
  logic [WORD_W-1:0] resp_word;
  logic [LONG-1:0]   resp_raw;

  sdcmd_regs #(.ADDR_W(ADDR_W), .RTO_W(RTO_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .start_p(start_p),
    .idx(idx), .arg(arg), .setup(setup), .rto(rto), .irq(irq),
    .resp_pop(resp_pop), .resp_word(resp_word), .busy(busy), .crc_err(crc_err),
    .done_p(done_p), .tout_p(tout_p)
  );

  sdcmd_seq #(.INIT_CYC(INIT_CYC), .RTO_W(RTO_W), .LONG(LONG), .SHORT(SHORT)) u_seq (
    .clk(clk), .rst(rst), .tick(cclk_en), .start(start_p), .idx(idx), .arg(arg),
    .fmt_in(setup[2:0]), .init_in(setup[7]), .rto(rto), .cmd_i(cmd_i),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .busy(busy), .crc_err(crc_err),
    .done_p(done_p), .tout_p(tout_p), .resp_load(resp_load),
    .resp_long(resp_long), .resp_raw(resp_raw)
  );

  sdcmd_resp #(.WORD_W(WORD_W), .LONG(LONG), .SHORT(SHORT)) u_resp (
    .clk(clk), .rst(rst), .load(resp_load), .is_long(resp_long), .raw(resp_raw),
    .pop(resp_pop), .word(resp_word)
  );

endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;

  logic clk = 1'b0, rst = 1'b1, cclk_en = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, cmd_i = 1'b1;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic cmd_o, cmd_oe, irq;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sdcmd_engine u_dut (
    .clk(clk), .rst(rst), .cclk_en(cclk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  function automatic logic [6:0] bcrc(input logic [135:0] v, input int hi);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = hi; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, bcrc(136'(h), 39), 1'b1};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // starts a command, records the wake burst and frame; returns at the first negedge with cmd_oe low
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [10:0] dat,
                       output int wake, output logic [47:0] fr, output int nbits);
    int n;
    bit seen;
    wr(4'd2, 32'(idx)); wr(4'd3, arg); wr(4'd4, 32'(dat));
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd0, 32'h4);
    wake = 0; nbits = 0; fr = '0; seen = 0; n = 0;
    while (!cmd_oe && n < 20) begin @(negedge clk); n++; end
    while (cmd_oe) begin
      if (!seen && cmd_o) wake++;
      else begin seen = 1; fr = {fr[46:0], cmd_o}; nbits++; end
      @(negedge clk);
    end
  endtask

  task automatic reply(input logic [135:0] v, input int len, input int k);
    repeat (k) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_i = v[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [47:0] short_reply(input logic [5:0] idx, input logic [31:0] p);
    logic [39:0] h;
    h = {2'b00, idx, p};
    return {h, bcrc(136'(h), 39), 1'b1};
  endfunction

  initial begin
    logic [31:0] d;
    logic [47:0] fr, r48;
    logic [135:0] r136;
    logic [143:0] lbuf;
    logic [119:0] p120;
    int wake, nb, oe_cnt;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10 cmd_oe", 64'(cmd_oe), 64'd0);
    chk("R10 irq", 64'(irq), 64'd0);
    rd(4'd1, d); chk("R10 status", 64'(d), 64'd0);
    rd(4'd7, d); chk("R10 flags", 64'(d), 64'd0);
    rd(4'd6, d); chk("R9 mask reset", 64'(d), 64'h204);

    // R1 R2 R4 sweep of all indices, no-response format, init on every fourth
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      logic [10:0] dt;
      a  = 32'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
      dt = ((i % 4) == 0) ? 11'h680 : 11'h618;
      issue(6'(i), a, dt, wake, fr, nb);
      chk("R1 frame bits", 64'(fr), 64'(exp_frame(6'(i), a)));
      chk("R1 frame length", 64'(nb), 64'd48);
      chk("R2 wake ticks", 64'(wake), ((i % 4) == 0) ? 64'd80 : 64'd0);
      repeat (2) @(negedge clk);
      rd(4'd7, d); chk("R4 done flag, no reply", 64'(d), 64'h4);
    end

    // R6 short reply, several payloads and formats
    wr(4'd5, 32'd20);
    for (int j = 0; j < 4; j++) begin
      logic [31:0] p;
      p = 32'hC3A5_0F01 + 32'(j) * 32'h1111_2223;
      issue(6'd17, 32'h1234_5678, 11'(j == 0 ? 1 : (j == 1 ? 6 : (j == 2 ? 5 : 4))), wake, fr, nb);
      r48 = short_reply(6'd17, p);
      reply(136'(r48), 48, 4);
      rd(4'd7, d); chk("R6 done after short reply", 64'(d), 64'h4);
      rd(4'd1, d); chk("R7 no crc error", 64'(d), 64'h0);
      rd(4'd8, d); chk("R6 word1 47:32", 64'(d), 64'(r48[47:32]));
      rd(4'd8, d); chk("R6 word2 31:16", 64'(d), 64'(r48[31:16]));
      rd(4'd8, d); chk("R6 word3 15:0", 64'(d), 64'(r48[15:0]));
    end

    // R6 long reply, two payloads
    for (int j = 0; j < 2; j++) begin
      p120 = {60'h0F1E_2D3C_4B5A_697, 60'h8796_A5B4_C3D2_E1F} ^ {4{30'(j * 30'h1555_5555)}};
      r136 = {8'h3F, p120, bcrc(136'(p120), 119), 1'b1};
      lbuf = {r136, 8'h00};
      issue(6'd2, 32'h0, 11'd2, wake, fr, nb);
      reply(r136, 136, 5);
      rd(4'd7, d); chk("R6 done after long reply", 64'(d), 64'h4);
      rd(4'd1, d); chk("R7 long crc ok", 64'(d), 64'h0);
      for (int w = 0; w < 9; w++) begin
        rd(4'd8, d);
        chk("R6 long word", 64'(d), 64'(lbuf[143 - 16*w -: 16]));
      end
    end

    // R7 corrupted short reply
    r48 = short_reply(6'd9, 32'hDEAD_BEEF) ^ 48'h10_0000;
    issue(6'd9, 32'h1, 11'd1, wake, fr, nb);
    reply(136'(r48), 48, 4);
    rd(4'd1, d); chk("R7 crc error set", 64'(d), 64'h20);
    rd(4'd7, d); chk("R7 done still set", 64'(d), 64'h4);

    // R7 format 3 with bad crc is not flagged; the error bit clears on the new start
    r48 = {2'b00, 6'h3F, 32'h80FF_8000, 7'h7F, 1'b1};
    issue(6'd41, 32'h0, 11'd3, wake, fr, nb);
    reply(136'(r48), 48, 4);
    rd(4'd1, d); chk("R7 format 3 exempt", 64'(d), 64'h0);

    // R7 corrupted long reply
    p120 = 120'h1;
    r136 = {8'h3F, p120, bcrc(136'(p120), 119) ^ 7'h1, 1'b1};
    issue(6'd2, 32'h0, 11'd2, wake, fr, nb);
    reply(r136, 136, 4);
    rd(4'd1, d); chk("R7 long crc error", 64'(d), 64'h20);

    // R5 timeout boundary with timeout value 6: start at last legal sample is accepted
    wr(4'd5, 32'd6);
    r48 = short_reply(6'd3, 32'h0BAD_F00D);
    issue(6'd3, 32'h7, 11'd1, wake, fr, nb);
    reply(136'(r48), 48, 7);
    rd(4'd7, d); chk("R5 start on last sample accepted", 64'(d), 64'h4);
    rd(4'd8, d); chk("R5 reply captured", 64'(d), 64'(r48[47:32]));

    // one tick later: timeout only
    issue(6'd3, 32'h7, 11'd1, wake, fr, nb);
    reply(136'(r48), 48, 8);
    rd(4'd7, d); chk("R5 late start times out", 64'(d), 64'h200);

    // no reply at all, then code-0 command without clearing: both flags
    issue(6'd3, 32'h7, 11'd1, wake, fr, nb);
    repeat (30) @(negedge clk);
    rd(4'd7, d); chk("R5 silent card timeout", 64'(d), 64'h200);
    chk("R9 masked irq low", 64'(irq), 64'd0);

    // R8 write-one-to-clear
    wr(4'd2, 32'd5); wr(4'd4, 32'd0); wr(4'd0, 32'h4);
    repeat (60) @(negedge clk);
    rd(4'd7, d); chk("R8 both flags", 64'(d), 64'h204);
    wr(4'd7, 32'h0); rd(4'd7, d); chk("R8 write zero keeps", 64'(d), 64'h204);
    wr(4'd7, 32'h4); rd(4'd7, d); chk("R8 clears done only", 64'(d), 64'h200);

    // R9 masking
    chk("R9 irq all masked", 64'(irq), 64'd0);
    wr(4'd6, 32'h004); repeat (2) @(negedge clk);
    chk("R9 irq timeout unmasked", 64'(irq), 64'd1);
    wr(4'd6, 32'h200); repeat (2) @(negedge clk);
    chk("R9 irq timeout masked", 64'(irq), 64'd0);
    wr(4'd6, 32'h000); repeat (2) @(negedge clk);
    chk("R9 irq all open", 64'(irq), 64'd1);
    wr(4'd7, 32'h200); repeat (2) @(negedge clk);
    chk("R9 irq after clear", 64'(irq), 64'd0);

    // R3 start during a frame is ignored
    wr(4'd4, 32'd0); wr(4'd7, 32'hFFFF_FFFF);
    oe_cnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (cmd_oe) oe_cnt++;
      wr_en   = (c == 0) || (c == 20);
      wr_addr = 4'd0;
      wr_data = 32'h4;
    end
    wr_en = 1'b0;
    chk("R3 single frame for two starts", 64'(oe_cnt), 64'd48);

    report();
  end

endmodule